// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date in a small bank of BCD registers. A once-per-second tick advances it. The tick comes from a prescaler outside the block. The bank holds seconds, minutes, hours in 24-hour form, day of week, day of month, month, a two-digit year and a century flag. Carries run from seconds up through the year. Month lengths and February in leap years are handled in logic.

A byte-wide register port lets a bus interface load any register directly and read the bank back. While the interface is reading the time, it raises a busy input. Tick updates are then held back, so that no digit changes in the middle of a multi-byte read. One held-back second is applied as soon as busy drops, so no time is lost. A stop flag freezes the clock. A century-enable flag decides whether the century bit flips when the year wraps.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, registers 0 to 6 read 0x00, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00 and register 7 reads 0x00.
- R2: Each applied tick adds one second. Seconds and minutes wrap 59 to 00 and carry into the next field. Hours wrap 23 to 00 and carry into the day.
- R3: At each midnight the day of week in register 3 bits 2:0 advances by one and wraps from 7 to 1.
- R4: The date wraps to 01 after the last day of its month and increments the month. April, June, September and November have 30 days; the other months except February have 31. The month wraps from 12 to 01 and increments the year.
- R5: February has 29 days when the BCD year is divisible by 4 (year 00 included) and 28 days otherwise.
- R6: Register 2 carries the century enable in bit 7 and the century bit in bit 6. When the year wraps from 99 to 00, the century bit inverts if the enable is 1 and stays unchanged if the enable is 0.
- R7: While the stop flag (register 0 bit 7) is 1, ticks are ignored and the time does not change.
- R8: While rd_busy is high, ticks change no register. At most one tick is held pending. It is applied on the first clock edge with rd_busy low, and further ticks during the same busy window are dropped.
- R9: A write to any of registers 0 to 6 discards a pending tick. A tick that arrives in the same cycle as such a write is discarded too.
- R10: Unused bits read as 0. The register layout is: reg0 {stop, sec[6:0]}, reg1 {0, min[6:0]}, reg2 {cen_en, cen, hr[5:0]}, reg3 {00000, dow[2:0]}, reg4 {00, date[5:0]}, reg5 {000, month[4:0]}, reg6 year[7:0]. Register 7 reads 0 and ignores writes.
- R11: A register write takes effect at the clock edge that samples it and is visible on reg_rdata right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second from the prescaler |
| rd_busy | input | 1 | High while a bus read of the time is in progress |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |

## Verification
The assertions check the following on every cycle: the seconds wrap, the day-of-week wrap at midnight, the century bit holding steady when its enable is clear, the stop flag freezing the seconds, and that no register moves without an applied tick or a write. They also follow the pending-tick flag: it is set during busy, it is cleared by a write, and it is released once. The bench scenarios are the only place the full calendar is shown: month lengths, leap Februaries, the year and century wrap, and the exact count of seconds gained after a busy window or a write that collides with a tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int DATA_W        = 8;
  localparam int ADDR_W        = 3;
  localparam int NUM_TIME_REGS = 7;

  typedef struct packed {
    logic       stop;
    logic [6:0] sec;
    logic [6:0] min;
    logic       cen_en;
    logic       cen;
    logic [5:0] hr;
    logic [2:0] dow;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] yr;
  } rtc_time_t;

  // Add one to a two-digit BCD value.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return v + 8'd1;
  endfunction

  // A BCD year tens*10+units is divisible by 4 exactly when 2*tens+units is.
  function automatic logic is_leap(input logic [7:0] yr);
    logic [4:0] s;
    s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  // Last day of a month, returned in BCD.
  function automatic logic [5:0] last_day(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_tick_gate.sv
module rtc_tick_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic busy_i,
  input  logic stop_i,
  input  logic wr_time_i,
  output logic apply_o,
  output logic pending_o
);

  logic pending_q;
  logic want;

  assign want      = (tick_i | pending_q) & ~stop_i;
  assign apply_o   = want & ~busy_i & ~wr_time_i;
  assign pending_o = pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          pending_q <= 1'b0;
    else if (wr_time_i)  pending_q <= 1'b0;
    else if (busy_i)     pending_q <= pending_q | (tick_i & ~stop_i);
    else                 pending_q <= 1'b0;
  end

  // R8: a tick seen during a read is remembered
  assert_defer_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && tick_i && !stop_i && !wr_time_i) |=> pending_q);

  // R8: the held tick is released only once
  assert_single_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !busy_i) |=> !pending_q);

  // R9: a time write discards any held tick
  assert_write_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_time_i |=> !pending_q);

endmodule

// File: rtl/rtc_step.sv
module rtc_step
  import rtc_pkg::*;
(
  input  rtc_time_t cur_i,
  output rtc_time_t nxt_o,
  output logic      min_carry_o,
  output logic      day_carry_o,
  output logic      yr_carry_o
);

  logic       sec_end, min_end, hr_end, date_end, mon_end, yr_end;
  logic       leap;
  logic [5:0] mlast;

  always_comb begin
    leap     = is_leap(cur_i.yr);
    mlast    = last_day(cur_i.mon, leap);
    sec_end  = (cur_i.sec == 7'h59);
    min_end  = sec_end & (cur_i.min == 7'h59);
    hr_end   = min_end & (cur_i.hr == 6'h23);
    date_end = hr_end & (cur_i.date >= mlast);
    mon_end  = date_end & (cur_i.mon >= 5'h12);
    yr_end   = mon_end & (cur_i.yr == 8'h99);

    nxt_o = cur_i;
    nxt_o.sec = sec_end ? 7'h00 : 7'(bcd_inc({1'b0, cur_i.sec}));
    if (sec_end)
      nxt_o.min = min_end ? 7'h00 : 7'(bcd_inc({1'b0, cur_i.min}));
    if (min_end)
      nxt_o.hr = hr_end ? 6'h00 : 6'(bcd_inc({2'b00, cur_i.hr}));
    if (hr_end) begin
      nxt_o.dow  = (cur_i.dow >= 3'd7) ? 3'd1 : cur_i.dow + 3'd1;
      nxt_o.date = date_end ? 6'h01 : 6'(bcd_inc({2'b00, cur_i.date}));
    end
    if (date_end)
      nxt_o.mon = mon_end ? 5'h01 : 5'(bcd_inc({3'b000, cur_i.mon}));
    if (mon_end)
      nxt_o.yr = yr_end ? 8'h00 : bcd_inc(cur_i.yr);
    if (yr_end)
      nxt_o.cen = cur_i.cen ^ cur_i.cen_en;
  end

  assign min_carry_o = sec_end;
  assign day_carry_o = hr_end;
  assign yr_carry_o  = yr_end;

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              apply_i,
  input  rtc_time_t         nxt_i,
  output rtc_time_t         cur_o,
  output logic              wr_time_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam logic [ADDR_W-1:0] LAST_TIME_ADDR = ADDR_W'(NUM_TIME_REGS - 1);

  rtc_time_t st_q;

  assign cur_o     = st_q;
  assign wr_time_o = we_i & (addr_i <= LAST_TIME_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= '0;
      st_q.dow  <= 3'd1;
      st_q.date <= 6'h01;
      st_q.mon  <= 5'h01;
    end else if (wr_time_o) begin
      case (addr_i)
        3'd0: begin st_q.stop <= wdata_i[7]; st_q.sec <= wdata_i[6:0]; end
        3'd1: st_q.min <= wdata_i[6:0];
        3'd2: begin
          st_q.cen_en <= wdata_i[7];
          st_q.cen    <= wdata_i[6];
          st_q.hr     <= wdata_i[5:0];
        end
        3'd3: st_q.dow  <= wdata_i[2:0];
        3'd4: st_q.date <= wdata_i[5:0];
        3'd5: st_q.mon  <= wdata_i[4:0];
        default: st_q.yr <= wdata_i;
      endcase
    end else if (apply_i) begin
      st_q <= nxt_i;
    end
  end

  always_comb begin
    case (addr_i)
      3'd0:    rdata_o = {st_q.stop, st_q.sec};
      3'd1:    rdata_o = {1'b0, st_q.min};
      3'd2:    rdata_o = {st_q.cen_en, st_q.cen, st_q.hr};
      3'd3:    rdata_o = {5'b0, st_q.dow};
      3'd4:    rdata_o = {2'b0, st_q.date};
      3'd5:    rdata_o = {3'b0, st_q.mon};
      3'd6:    rdata_o = st_q.yr;
      default: rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              rd_busy,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);

  rtc_time_t cur, nxt;
  logic      apply, pending, wr_time;
  logic      min_carry, day_carry, yr_carry;

  rtc_tick_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_1hz),
    .busy_i    (rd_busy),
    .stop_i    (cur.stop),
    .wr_time_i (wr_time),
    .apply_o   (apply),
    .pending_o (pending)
  );

  rtc_step u_step (
    .cur_i       (cur),
    .nxt_o       (nxt),
    .min_carry_o (min_carry),
    .day_carry_o (day_carry),
    .yr_carry_o  (yr_carry)
  );

  rtc_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (reg_we),
    .addr_i    (reg_addr),
    .wdata_i   (reg_wdata),
    .apply_i   (apply),
    .nxt_i     (nxt),
    .cur_o     (cur),
    .wr_time_o (wr_time),
    .rdata_o   (reg_rdata)
  );

  // R2: an applied tick at second 59 lands on 00 and carries
  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && min_carry) |=> (cur.sec == 7'h00));

  // R3: day of week wraps 7 -> 1 at midnight
  assert_dow_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && day_carry && cur.dow == 3'd7) |=> (cur.dow == 3'd1));

  // R6: the century bit holds when its enable is clear
  assert_century_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur.cen_en && !reg_we) |=> $stable(cur.cen));

  // R6: with the enable set, the year wrap flips the century bit
  assert_century_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && yr_carry && cur.cen_en) |=> (cur.cen != $past(cur.cen)));

  // R7: stopped clock does not count
  assert_stop_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.stop && !reg_we) |=> $stable(cur.sec));

  // R8: nothing moves without an applied tick or a write
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!apply && !wr_time) |=> $stable(cur));

  // R8: a busy read never sees an update
  assert_busy_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && !reg_we) |=> $stable(cur));

  // R8: a pending tick only exists while a read was in progress
  assert_pending_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> $past(rd_busy));

endmodule

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       rd_busy = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc_core dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .rd_busy(rd_busy),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // {expected, initial}; each half is {r6,r5,r4,r3,r2,r1,r0}
  localparam logic [111:0] VEC [NV] = '{
    {56'h00010101000001, 56'h00010101000000}, // R2 plain second
    {56'h00010101000010, 56'h00010101000009}, // R2 units carry
    {56'h00010101123500, 56'h00010101123459}, // R2 minute carry
    {56'h30121502100000, 56'h30121502095959}, // R2 hour carry
    {56'h24061601000000, 56'h24061507235959}, // R3 dow 7 -> 1
    {56'h21050104000000, 56'h21043003235959}, // R4 30-day month
    {56'h21020103000000, 56'h21013102235959}, // R4 31-day month
    {56'h30100103000000, 56'h30093002235959}, // R4 Sep -> Oct
    {56'h30120103000000, 56'h30113002235959}, // R4 Nov -> Dec
    {56'h23030106000000, 56'h23022805235959}, // R5 common Feb
    {56'h24022904000000, 56'h24022803235959}, // R5 leap Feb 28
    {56'h24030105000000, 56'h24022904235959}, // R5 leap Feb 29
    {56'h00022902000000, 56'h00022801235959}, // R5 year 00 leap
    {56'h12022907000000, 56'h12022806235959}, // R5 year 12 leap
    {56'h10030101000000, 56'h10022807235959}, // R5 year 10 common
    {56'h00010106C00000, 56'h99123105A35959}, // R6 century flips
    {56'h00010106400000, 56'h99123105635959}, // R6 century held
    {56'h46010106800000, 56'h45123105A35959}  // R4 year carry, R6 no flip
  };
  localparam int TAG [NV] = '{2,2,2,2,3,4,4,4,4,5,5,5,5,5,5,6,6,6};

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load7(input logic [55:0] v);
    for (int i = 0; i < 7; i++) wr(3'(i), v[8*i +: 8]);
  endtask

  task automatic read7(output logic [55:0] v);
    logic [7:0] b;
    v = '0;
    for (int i = 0; i < 7; i++) begin
      rd(3'(i), b);
      v[8*i +: 8] = b;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [55:0] got;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    read7(got);
    check("R1 reset bank", 64'(got), 64'h00010101000000);
    rd(3'd7, b);
    check("R1 reg7 reset", 64'(b), 64'h00);

    // Table walk: R2 R3 R4 R5 R6
    for (int n = 0; n < NV; n++) begin
      load7(VEC[n][55:0]);
      pulse_tick();
      read7(got);
      check($sformatf("R%0d vector %0d", TAG[n], n), 64'(got), 64'(VEC[n][111:56]));
    end

    // R11 direct load
    wr(3'd6, 8'h42);
    rd(3'd6, b);
    check("R11 direct load", 64'(b), 64'h42);

    // R10 unused bits read as zero
    wr(3'd3, 8'hFF); rd(3'd3, b); check("R10 dow mask", 64'(b), 64'h07);
    wr(3'd4, 8'hFF); rd(3'd4, b); check("R10 date mask", 64'(b), 64'h3F);
    wr(3'd5, 8'hFF); rd(3'd5, b); check("R10 month mask", 64'(b), 64'h1F);
    wr(3'd1, 8'hFF); rd(3'd1, b); check("R10 minute mask", 64'(b), 64'h7F);
    wr(3'd7, 8'hAB); rd(3'd7, b); check("R10 reg7 ignores writes", 64'(b), 64'h00);

    load7(56'h24061503120000);

    // R7 stop bit freezes time
    wr(3'd0, 8'h90);
    repeat (3) pulse_tick();
    rd(3'd0, b); check("R7 stopped", 64'(b), 64'h90);
    wr(3'd0, 8'h10);
    pulse_tick();
    rd(3'd0, b); check("R7 restarted", 64'(b), 64'h11);

    // R8 deferral: three ticks during busy give one second
    @(negedge clk); rd_busy = 1'b1;
    repeat (3) pulse_tick();
    rd(3'd0, b); check("R8 held during busy", 64'(b), 64'h11);
    @(negedge clk); rd_busy = 1'b0;
    @(negedge clk); @(negedge clk);
    rd(3'd0, b); check("R8 one deferred tick applied", 64'(b), 64'h12);

    // R9 write discards the pending tick
    wr(3'd0, 8'h20);
    @(negedge clk); rd_busy = 1'b1;
    pulse_tick();
    wr(3'd1, 8'h05);
    @(negedge clk); rd_busy = 1'b0;
    @(negedge clk); @(negedge clk);
    rd(3'd0, b); check("R9 pending dropped by write", 64'(b), 64'h20);
    rd(3'd1, b); check("R9 written minute", 64'(b), 64'h05);

    // R9 tick colliding with a write is dropped
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h30; tick_1hz = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; tick_1hz = 1'b0;
    @(negedge clk);
    rd(3'd0, b); check("R9 colliding tick dropped", 64'(b), 64'h30);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule